// File: doc/BRIEF.md
# Serial Bus Command Frame Encoder

This block turns one read or write request for a two-wire chip-management serial bus into a command frame. It then shifts that frame out one bit per clock, most significant bit first. A request carries a 2-bit target ID, a 21-bit byte address, an access size and a direction flag. A write also carries up to four data bytes. The block tracks the address of the last access that completed cleanly. From that state it picks the shortest address form that still names the target: a same-word form, a short signed offset form, or a full absolute form. The access size is folded into the low address bits and a data-size bit.

A 4-bit check code closes every frame. The block reports the frame length in bits while the frame is on the wire. It strobes each bit with a valid flag and marks the last bit with a done pulse. A separate response-status input tells the block how the last frame ended. A clean response makes that frame's word address the new reference. A check-code error or a nonzero response tag throws the reference away, so the next request is sent in absolute form.

Top module: `cmd_frame_enc`

## Requirements
- R1: A frame is sent in this order: ID (2 bits), opcode, direction bit (1 = read, 0 = write), address field, data-size bit, write bytes, check code (4 bits). Frames are 12 to 64 bits long.
- R2: Absolute form uses opcode `100` and the full 21-bit address. It is used after reset, after invalidation, when the request ID differs from the stored ID, and when no shorter form applies.
- R3: Offset form uses opcode `101` and a 9-bit two's-complement field equal to the request address minus the stored word address. It is used only when that difference is between -256 and +255 inclusive and the IDs match.
- R4: Same-word form uses opcode `11` and sends only address bits 1:0. It is used when the ID matches and the word-aligned request address equals the stored word address. It takes priority over the offset form.
- R5: Size code `req_size` is 00 for 1 byte, 01 for 2 bytes, and 10 or 11 for 4 bytes. For 1 byte the data-size bit is 0 and the field is unchanged. For 2 bytes the data-size bit is 1 and field bit 0 is forced to 0. For 4 bytes the data-size bit is 1 and field bits 1:0 are forced to 01.
- R6: A write sends its bytes in order: `req_wdata[7:0]` first, then bits 15:8, and so on, each byte MSB first. A read sends no data bytes.
- R7: The check code uses polynomial x^4+x^2+x+1 with a zero start value. It is computed MSB first over an implicit leading 1 followed by every frame bit before the code.
- R8: The first frame bit appears in the cycle after acceptance. `ser_valid` stays high for exactly `frame_len` consecutive cycles, and `frame_done` is high with the last bit.
- R9: `req_ready` is low while a frame is shifting. Requests presented then are ignored and start no frame.
- R10: After reset, `ser_valid` and `frame_done` are low, `req_ready` is high, and the stored reference is invalid.
- R11: A response with `rsp_crc_err` = 0 and `rsp_tag` = 00 stores the ID and word address of the outstanding frame. Any other response invalidates the stored reference. A response with no outstanding frame has no effect.
- R12: When a response and a request acceptance fall in the same cycle, the new frame is encoded from the stored reference as it was before that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | 2 | Target ID |
| req_addr | input | 21 | Byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| rsp_valid | input | 1 | Response status present |
| rsp_crc_err | input | 1 | Response failed its check code |
| rsp_tag | input | 2 | Response tag, 00 = success |
| ser_data | output | 1 | Serial frame bit |
| ser_valid | output | 1 | Serial bit valid |
| frame_done | output | 1 | Last bit of the frame |
| frame_len | output | 7 | Bit count of the current frame |

## Verification
A response update to the stored reference can land in the same clock edge as the acceptance of a new request. The bench provokes this by raising `rsp_valid` together with `req_valid`, both in directed steps and at random. It judges the result by rebuilding the expected frame from the reference as it stood before the edge, and then applying the response to its own model. A same-cycle hit that used the updated reference would show up as a same-word frame where an absolute frame was expected.

// File: rtl/cmd_frame_enc.sv
module cmd_frame_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_id,
  input  logic [20:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_crc_err,
  input  logic [1:0]  rsp_tag,
  output logic        ser_data,
  output logic        ser_valid,
  output logic        frame_done,
  output logic [6:0]  frame_len
);

  localparam int FW = 64;

  logic          busy;
  logic [FW-1:0] sh;
  logic [6:0]    left;
  logic [6:0]    flen;
  logic          last_vld;
  logic [1:0]    last_id;
  logic [20:0]   last_a;
  logic          pend_vld;
  logic [1:0]    pend_id;
  logic [20:0]   pend_a;

  wire        accept   = req_valid && !busy;
  wire [20:0] word_a   = {req_addr[20:2], 2'b00};
  wire [21:0] diff     = {1'b0, req_addr} - {1'b0, last_a};
  wire        id_hit   = last_vld && (last_id == req_id);
  wire        use_same = id_hit && (last_a == word_a);
  wire        use_rel  = id_hit && !use_same &&
                         ((diff[21:8] == 14'h0000) || (diff[21:8] == 14'h3fff));
  wire        ds       = (req_size != 2'b00);
  wire [2:0]  nbytes   = (req_size == 2'b00) ? 3'd1 : (req_size == 2'b01) ? 3'd2 : 3'd4;

  logic [20:0]   fld;
  logic [FW-1:0] m;
  logic [6:0]    n;
  logic [3:0]    crc;
  logic          fb;

  always_comb begin
    fld = use_same ? {19'b0, req_addr[1:0]} : use_rel ? {12'b0, diff[8:0]} : req_addr;
    if (ds)          fld[0]   = 1'b0;
    if (req_size[1]) fld[1:0] = 2'b01;

    m = {62'b0, req_id};
    n = 7'd2;
    if (use_same) begin
      m = {m[61:0], 2'b11};
      n = n + 7'd2;
    end else begin
      m = {m[60:0], 2'b10, use_rel};
      n = n + 7'd3;
    end
    m = {m[62:0], !req_write};
    n = n + 7'd1;
    if (use_same) begin
      m = {m[61:0], fld[1:0]};
      n = n + 7'd2;
    end else if (use_rel) begin
      m = {m[54:0], fld[8:0]};
      n = n + 7'd9;
    end else begin
      m = {m[42:0], fld};
      n = n + 7'd21;
    end
    m = {m[62:0], ds};
    n = n + 7'd1;
    for (int b = 0; b < 4; b++) begin
      if (req_write && (b < int'(nbytes))) begin
        m = {m[55:0], req_wdata[8*b +: 8]};
        n = n + 7'd8;
      end
    end

    crc = 4'b0111;
    fb  = 1'b0;
    for (int i = 59; i >= 0; i--) begin
      if (i < int'(n)) begin
        fb  = crc[3] ^ m[i];
        crc = {crc[2:0], 1'b0} ^ {1'b0, fb, fb, fb};
      end
    end
    m = {m[59:0], crc};
    n = n + 7'd4;
  end

  wire [FW-1:0] m_al = m << (7'd64 - n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sh       <= '0;
      left     <= '0;
      flen     <= '0;
      last_vld <= 1'b0;
      last_id  <= '0;
      last_a   <= '0;
      pend_vld <= 1'b0;
      pend_id  <= '0;
      pend_a   <= '0;
    end else begin
      if (rsp_valid && pend_vld) begin
        pend_vld <= 1'b0;
        if (rsp_crc_err || (rsp_tag != 2'b00)) begin
          last_vld <= 1'b0;
        end else begin
          last_vld <= 1'b1;
          last_id  <= pend_id;
          last_a   <= pend_a;
        end
      end
      if (accept) begin
        pend_vld <= 1'b1;
        pend_id  <= req_id;
        pend_a   <= word_a;
        sh       <= m_al;
        left     <= n;
        flen     <= n;
        busy     <= 1'b1;
      end else if (busy) begin
        sh   <= {sh[FW-2:0], 1'b0};
        left <= left - 7'd1;
        if (left == 7'd1) busy <= 1'b0;
      end
    end
  end

  assign req_ready  = !busy;
  assign ser_valid  = busy;
  assign ser_data   = busy & sh[FW-1];
  assign frame_done = busy && (left == 7'd1);
  assign frame_len  = flen;

  // R8
  end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !ser_valid);

  // R8
  burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !frame_done) |=> (ser_valid && $stable(frame_len)));

  // R8
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> $past(req_valid));

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (frame_len >= 7'd12 && frame_len <= 7'd64));

  // R11
  bad_rsp_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pend_vld && (rsp_crc_err || rsp_tag != 2'b00)) |=> !last_vld);

endmodule

// File: tb/cmd_frame_enc_tb.sv
module cmd_frame_enc_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_id;
  logic [20:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_crc_err;
  logic [1:0]  rsp_tag;
  logic        ser_data, ser_valid, frame_done;
  logic [6:0]  frame_len;

  always #10 clk = ~clk;

  cmd_frame_enc u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_crc_err(rsp_crc_err), .rsp_tag(rsp_tag),
    .ser_data(ser_data), .ser_valid(ser_valid), .frame_done(frame_done),
    .frame_len(frame_len)
  );

  int checks = 0;
  int fails  = 0;

  logic        m_vld, p_vld;
  logic [1:0]  m_id, p_id;
  logic [20:0] m_a, p_a;
  logic [63:0] exp_bits;
  int          exp_n;
  int          exp_mode;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic push(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      exp_bits[63 - exp_n] = v[k];
      exp_n++;
    end
  endtask

  task automatic build(input logic [1:0] id, input logic [20:0] addr, input logic [1:0] size,
                       input logic wr, input logic [31:0] wd);
    int d;
    logic [31:0] f;
    int w;
    int nb;
    logic [3:0] c;
    logic fbk;
    exp_bits = '0;
    exp_n = 0;
    d = int'(addr) - int'(m_a);
    if (m_vld && m_id == id && m_a == {addr[20:2], 2'b00}) begin
      exp_mode = 2; f = {30'b0, addr[1:0]}; w = 2;
    end else if (m_vld && m_id == id && d >= -256 && d <= 255) begin
      exp_mode = 1; f = d & 32'h1ff; w = 9;
    end else begin
      exp_mode = 0; f = {11'b0, addr}; w = 21;
    end
    if (size == 2'd1) f[0] = 1'b0;
    if (size >= 2'd2) f[1:0] = 2'b01;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    push({30'b0, id}, 2);
    if (exp_mode == 2) push(32'h3, 2);
    else push((exp_mode == 1) ? 32'h5 : 32'h4, 3);
    push({31'b0, !wr}, 1);
    push(f, w);
    push({31'b0, size != 0}, 1);
    if (wr) for (int b = 0; b < nb; b++) push({24'b0, wd[8*b +: 8]}, 8);
    c = 4'h0;
    fbk = c[3] ^ 1'b1;
    c = {c[2:0], 1'b0};
    if (fbk) c = c ^ 4'h7;
    for (int k = 0; k < exp_n; k++) begin
      fbk = c[3] ^ exp_bits[63 - k];
      c = {c[2:0], 1'b0};
      if (fbk) c = c ^ 4'h7;
    end
    push({28'b0, c}, 4);
  endtask

  task automatic model_rsp(input bit err, input logic [1:0] tag);
    if (p_vld) begin
      if (err || tag != 2'b00) m_vld = 1'b0;
      else begin m_vld = 1'b1; m_id = p_id; m_a = p_a; end
    end
    p_vld = 1'b0;
  endtask

  task automatic idle_rsp(input bit err, input logic [1:0] tag);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_crc_err = err; rsp_tag = tag;
    model_rsp(err, tag);
    @(negedge clk);
    rsp_valid = 1'b0; rsp_crc_err = 1'b0; rsp_tag = 2'b00;
  endtask

  task automatic run(input logic [1:0] id, input logic [20:0] addr, input logic [1:0] size,
                     input logic wr, input logic [31:0] wd,
                     input bit with_rsp, input bit rerr, input logic [1:0] rtag,
                     input bit disturb, input int fixlen, input string fixtag);
    logic [63:0] got;
    logic [63:0] mask;
    int cnt;
    string mtag;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready before request", req_ready, 1);
    build(id, addr, size, wr, wd);
    mtag = (exp_mode == 2) ? "R4" : (exp_mode == 1) ? "R3" : "R2";
    req_valid = 1'b1; req_id = id; req_addr = addr; req_size = size;
    req_write = wr; req_wdata = wd;
    if (with_rsp) begin
      rsp_valid = 1'b1; rsp_crc_err = rerr; rsp_tag = rtag;
      model_rsp(rerr, rtag);
    end
    p_vld = 1'b1; p_id = id; p_a = {addr[20:2], 2'b00};
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0; rsp_crc_err = 1'b0; rsp_tag = 2'b00;
    got = '0;
    cnt = 0;
    while (1) begin
      if (!ser_valid) begin
        chk(1'b0, "R8", "ser_valid dropped early", cnt, exp_n);
        break;
      end
      got[63 - cnt] = ser_data;
      cnt++;
      if (disturb) chk(req_ready === 1'b0, "R9", "ready while shifting", req_ready, 0);
      if (frame_done) begin req_valid = 1'b0; break; end
      if (cnt >= 70) break;
      if (disturb && cnt == 2) begin
        req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_id = ~id;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(cnt == exp_n, "R8", "bits between start and frame_done", cnt, exp_n);
    chk(int'(frame_len) == exp_n, "R8", "frame_len", frame_len, exp_n);
    mask = ~64'h0 << (64 - exp_n);
    chk(((got ^ exp_bits) & mask) == 64'h0, {mtag, " R1 R5 R6 R7"}, "frame bits",
        got, exp_bits);
    if (fixlen > 0) chk(cnt == fixlen, fixtag, "frame length", cnt, fixlen);
    @(negedge clk);
    chk(!ser_valid && req_ready, "R9", "idle after frame", {ser_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_wdata = '0; rsp_valid = 1'b0; rsp_crc_err = 1'b0; rsp_tag = '0;
    m_vld = 1'b0; m_id = '0; m_a = '0; p_vld = 1'b0; p_id = '0; p_a = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!ser_valid && !frame_done && req_ready, "R10", "outputs after reset",
        {ser_valid, frame_done, req_ready}, 3'b001);

    run(0, 21'h0, 2, 0, 0, 0, 0, 0, 0, 32, "R10");
    idle_rsp(0, 0);
    run(0, 21'h0, 2, 0, 0, 0, 0, 0, 0, 12, "R4");
    run(0, 21'h2, 0, 0, 0, 0, 0, 0, 0, 12, "R4");
    idle_rsp(0, 0);
    run(0, 21'h1000, 2, 0, 0, 0, 0, 0, 0, 32, "R2");
    idle_rsp(0, 0);
    run(0, 21'h10FF, 0, 0, 0, 0, 0, 0, 0, 20, "R3");
    run(0, 21'h1100, 0, 0, 0, 0, 0, 0, 0, 32, "R3");
    run(0, 21'h0F00, 1, 0, 0, 0, 0, 0, 0, 20, "R3");
    run(0, 21'h0EFF, 0, 0, 0, 0, 0, 0, 0, 32, "R3");
    run(1, 21'h1000, 2, 0, 0, 0, 0, 0, 0, 32, "R2");
    run(0, 21'h1000, 2, 1, 32'hA5C31E0F, 0, 0, 0, 0, 44, "R6");
    run(0, 21'h1004, 1, 1, 32'h00005A3C, 0, 0, 0, 0, 36, "R6");
    run(2, 21'h1ABCDE, 2, 1, 32'h12345678, 0, 0, 0, 0, 64, "R1");
    idle_rsp(0, 2'b01);
    run(0, 21'h1000, 2, 0, 0, 0, 0, 0, 0, 32, "R11");
    idle_rsp(1, 0);
    idle_rsp(0, 0);
    run(0, 21'h1000, 2, 0, 0, 0, 0, 0, 0, 32, "R11");
    run(0, 21'h1000, 2, 0, 0, 1, 0, 0, 0, 32, "R12");
    run(0, 21'h1000, 2, 0, 0, 0, 0, 0, 0, 12, "R12");
    run(0, 21'h1000, 2, 0, 0, 0, 0, 0, 1, 12, "R9");

    for (int t = 0; t < 300; t++) begin
      logic [1:0] id;
      logic [20:0] a;
      int sel;
      int v;
      id = (($urandom % 4) == 0) ? 2'($urandom % 4) : m_id;
      sel = $urandom % 4;
      if (sel == 0) v = int'(m_a) + int'($urandom % 8);
      else if (sel == 1) v = int'(m_a) + int'($urandom % 601) - 300;
      else v = int'($urandom);
      a = 21'(v & 32'h1FFFFF);
      run(id, a, 2'($urandom % 4), 1'($urandom % 2), $urandom,
          ($urandom % 5) == 0, ($urandom % 8) == 0, (($urandom % 8) == 0) ? 2'($urandom) : 2'b00,
          ($urandom % 10) == 0, 0, "R1");
      if (($urandom % 2) == 0) idle_rsp(($urandom % 8) == 0, (($urandom % 8) == 0) ? 2'($urandom) : 2'b00);
    end

    report();
    $finish;
  end

endmodule